// File: doc/BRIEF.md
# Chainable serial-to-parallel converter with holding register

The block turns a serial bit stream into a parallel word. Bits enter a shift chain on the rising edge of a shift clock, and a separate storage clock copies the whole chain into a holding register in one step. The parallel outputs always show the holding register. Software or a controller can therefore shift a new word in over many cycles while the outputs keep the previous word, and then update every output bit at the same moment.

The chain is built from `NUM_DEV` sections of 8 stages each, which gives a word of 8×`NUM_DEV` bits. The cascade output comes from the last shift stage, not from the holding register, so it can drive the serial input of a further block. The shift side and the holding side each have their own clock and their own active-low asynchronous clear, and the two clock domains may be completely unrelated.

Top module: `sipo_hold_chain`

## Requirements
- R1: While both clears are low, `par_o` and `cas_o` are all zero.
- R2: On each rising edge of `shift_clk_i` with `shift_rst_ni` high, `ser_i` loads into stage 0 and every stage k takes the earlier value of stage k-1. The data is not inverted.
- R3: On each rising edge of `hold_clk_i` with `hold_rst_ni` high, the holding register captures every shift stage at once. Stage i drives `par_o[i]`, so the most recently shifted bit appears on `par_o[0]`.
- R4: A low `shift_rst_ni` clears all shift stages at once, without a clock, and overrides `shift_clk_i`. `par_o` does not change until the next holding edge, and that edge loads zeros.
- R5: A low `hold_rst_ni` clears `par_o` at once, without a clock, and overrides `hold_clk_i`. The shift contents are unaffected, so the first holding edge after release shows them.
- R6: `cas_o` equals the last shift stage, which is the bit shifted in 8×`NUM_DEV` edges earlier. A word of 8×`NUM_DEV` bits sent MSB first appears unchanged on `par_o`.
- R7: When the two clocks are tied together, each edge loads the holding register with the shift contents from before that edge, so the holding register lags by one pulse.
- R8: The two clocks may run at unrelated periods and phases. Every holding edge that meets setup from the shift stages shows the bits shifted before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk_i | input | 1 | Shift chain clock, rising edge |
| shift_rst_ni | input | 1 | Asynchronous active-low clear of the shift chain |
| hold_clk_i | input | 1 | Holding register clock, rising edge |
| hold_rst_ni | input | 1 | Asynchronous active-low clear of the holding register |
| ser_i | input | 1 | Serial data into stage 0 |
| par_o | output | 8×NUM_DEV | Holding register contents |
| cas_o | output | 1 | Last shift stage, used for cascading |

## Verification
The hardest case to reach is a holding edge that lands on the same instant as a shift edge. This happens with tied clocks, where the holding register must take the contents from before the shift. The bench feeds both clock pins from the same net for a stretch of cycles. Its reference model reads the shifted-bit queue at the edge before it records the new bit. A second phase runs the storage clock freely on odd nanoseconds against the shift clock's even-nanosecond edges. The clears are pulsed mid-cycle and held across an edge of the clock they override.

// File: rtl/sipo_pkg.sv
`timescale 1ns/1ps
package sipo_pkg;
  localparam int unsigned DEV_BITS = 8;
  typedef logic [DEV_BITS-1:0] dev_word_t;
endpackage

// File: rtl/sipo_shift_dev.sv
`timescale 1ns/1ps
module sipo_shift_dev
  import sipo_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ser_i,
  output dev_word_t stg_o,
  output logic      ser_o
);
  dev_word_t stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[DEV_BITS-2:0], ser_i};
  end

  assign stg_o = stg_q;
  assign ser_o = stg_q[DEV_BITS-1];
endmodule

// File: rtl/sipo_hold_dev.sv
`timescale 1ns/1ps
module sipo_hold_dev
  import sipo_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  dev_word_t d_i,
  output dev_word_t q_o
);
  dev_word_t q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/sipo_hold_chain.sv
`timescale 1ns/1ps
module sipo_hold_chain
  import sipo_pkg::*;
#(
  parameter int unsigned NUM_DEV = 2
) (
  input  logic                          shift_clk_i,
  input  logic                          shift_rst_ni,
  input  logic                          hold_clk_i,
  input  logic                          hold_rst_ni,
  input  logic                          ser_i,
  output logic [NUM_DEV*DEV_BITS-1:0]   par_o,
  output logic                          cas_o
);
  localparam int unsigned W = NUM_DEV * DEV_BITS;

  logic [NUM_DEV:0] link;
  logic [W-1:0]     sh_q;

  assign link[0] = ser_i;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    dev_word_t stg;

    sipo_shift_dev u_shift (
      .clk_i (shift_clk_i),
      .rst_ni(shift_rst_ni),
      .ser_i (link[d]),
      .stg_o (stg),
      .ser_o (link[d+1])
    );

    // holding side samples shift stages straight across domains
    sipo_hold_dev u_hold (
      .clk_i (hold_clk_i),
      .rst_ni(hold_rst_ni),
      .d_i   (stg),
      .q_o   (par_o[d*DEV_BITS +: DEV_BITS])
    );

    assign sh_q[d*DEV_BITS +: DEV_BITS] = stg;
  end

  assign cas_o = link[NUM_DEV];
endmodule

// File: rtl/sipo_hold_chain_chk.sv
`timescale 1ns/1ps
module sipo_hold_chain_chk #(
  parameter int unsigned W = 16
) (
  input logic         shift_clk_i,
  input logic         shift_rst_ni,
  input logic         hold_clk_i,
  input logic         hold_rst_ni,
  input logic         ser_i,
  input logic [W-1:0] sh_q,
  input logic [W-1:0] par_o,
  input logic         cas_o
);
  a_r2_stage_advance: assert property (@(posedge shift_clk_i) disable iff (!shift_rst_ni)
    $past(shift_rst_ni) |-> sh_q == {$past(sh_q[W-2:0]), $past(ser_i)});

  a_r3_parallel_capture: assert property (@(posedge hold_clk_i) disable iff (!hold_rst_ni)
    $past(hold_rst_ni) |-> par_o == $past(sh_q));

  a_r6_cascade_tap: assert property (@(posedge shift_clk_i) disable iff (!shift_rst_ni)
    $past(shift_rst_ni) |-> cas_o == $past(sh_q[W-2]));

  always @(posedge shift_clk_i) begin
    if (shift_rst_ni === 1'b0) begin
      a_r4_shift_cleared: assert (sh_q == '0 && cas_o == 1'b0);
    end
  end

  always @(posedge hold_clk_i) begin
    if (hold_rst_ni === 1'b0) begin
      a_r5_hold_cleared: assert (par_o == '0);
    end
  end
endmodule

bind sipo_hold_chain sipo_hold_chain_chk #(.W(NUM_DEV * sipo_pkg::DEV_BITS)) u_chk (
  .shift_clk_i (shift_clk_i),
  .shift_rst_ni(shift_rst_ni),
  .hold_clk_i  (hold_clk_i),
  .hold_rst_ni (hold_rst_ni),
  .ser_i       (ser_i),
  .sh_q        (sh_q),
  .par_o       (par_o),
  .cas_o       (cas_o)
);

// File: tb/tb_sipo_hold_chain.sv
`timescale 1ns/1ps
module tb_sipo_hold_chain;
  localparam int unsigned NUM_DEV = 2;
  localparam int unsigned W = NUM_DEV * 8;

  logic shift_clk = 1'b0;
  logic shift_rst_ni, hold_rst_ni, ser_i;
  logic hold_drv = 1'b0;
  logic tie = 1'b0;
  logic hold_clk;
  logic [W-1:0] par_o;
  logic cas_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R3";
  bit ref_q[$];
  logic [W-1:0] hold_model = '0;

  always #2 shift_clk = ~shift_clk;
  assign hold_clk = tie ? shift_clk : hold_drv;

  sipo_hold_chain #(.NUM_DEV(NUM_DEV)) dut (
    .shift_clk_i (shift_clk),
    .shift_rst_ni(shift_rst_ni),
    .hold_clk_i  (hold_clk),
    .hold_rst_ni (hold_rst_ni),
    .ser_i       (ser_i),
    .par_o       (par_o),
    .cas_o       (cas_o)
  );

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] word_now();
    logic [W-1:0] w = '0;
    for (int j = 0; j < ref_q.size(); j++) w[j] = ref_q[j];
    return w;
  endfunction

  // reference queue: newest bit at index 0, recorded just after the edge
  always @(posedge shift_clk) begin
    logic b, r;
    b = ser_i;
    r = shift_rst_ni;
    #0.1;
    if (r === 1'b1) begin
      ref_q.push_front(b);
      if (ref_q.size() > W) void'(ref_q.pop_back());
    end
  end

  always @(negedge shift_rst_ni) ref_q.delete();

  // monitor: holding edges
  always @(posedge hold_clk) begin
    if (hold_rst_ni === 1'b1) hold_model = word_now();
    else                      hold_model = '0;
    #1 chk(par_o, hold_model, cur_req);
  end

  // monitor: cascade tap, R6
  always @(negedge shift_clk) begin
    logic e;
    e = (ref_q.size() == W) ? ref_q[W-1] : 1'b0;
    if (shift_rst_ni === 1'b1 || shift_rst_ni === 1'b0)
      chk({{(W-1){1'b0}}, cas_o}, {{(W-1){1'b0}}, e}, "R6");
  end

  task automatic send_bit(input logic b);
    @(negedge shift_clk) ser_i = b;
  endtask

  task automatic send_word(input logic [W-1:0] w);
    for (int i = W-1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic hold_pulse();
    @(negedge shift_clk);
    #1 hold_drv = 1'b1;
    #1.5 hold_drv = 1'b0;
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    shift_rst_ni = 1'b0;
    hold_rst_ni  = 1'b0;
    ser_i        = 1'b0;
    #9;
    chk(par_o, '0, "R1");
    chk({{(W-1){1'b0}}, cas_o}, '0, "R1");
    @(negedge shift_clk);
    shift_rst_ni = 1'b1;
    hold_rst_ni  = 1'b1;

    // R2 R3 R6: full word through both sections
    cur_req = "R6";
    send_word(16'hA5C3);
    hold_pulse();
    chk(par_o, 16'hA5C3, "R6");
    cur_req = "R2";
    send_word(16'h1E7F);
    hold_pulse();
    cur_req = "R3";
    for (int i = 0; i < 5; i++) send_bit(i[0]);
    hold_pulse();

    // R4: shift clear leaves outputs, overrides clock, next edge loads zeros
    cur_req = "R4";
    send_word(16'h3C96);
    hold_pulse();
    @(negedge shift_clk);
    #0.5 shift_rst_ni = 1'b0;
    ser_i = 1'b1;
    #0.5 chk(par_o, 16'h3C96, "R4");
    chk({{(W-1){1'b0}}, cas_o}, '0, "R4");
    @(posedge shift_clk);
    hold_pulse();
    chk(par_o, '0, "R4");
    @(negedge shift_clk) shift_rst_ni = 1'b1;

    // R5: hold clear immediate, overrides clock, shift kept
    cur_req = "R5";
    send_word(16'hC001);
    hold_pulse();
    @(negedge shift_clk);
    #0.5 hold_rst_ni = 1'b0;
    hold_model = '0;
    #0.5 chk(par_o, '0, "R5");
    hold_pulse();
    hold_rst_ni = 1'b1;
    hold_pulse();

    // R7: tied clocks, holding lags by one pulse
    cur_req = "R7";
    @(negedge shift_clk) tie = 1'b1;
    for (int i = 0; i < 12; i++) send_bit(i[1] ^ i[0]);
    @(negedge shift_clk) tie = 1'b0;

    // R8: free-running storage clock on unrelated phase
    cur_req = "R8";
    fork
      send_word(16'h6B2D);
      begin
        @(negedge shift_clk);
        #1;
        repeat (20) begin
          hold_drv = ~hold_drv;
          #3;
        end
      end
    join
    hold_pulse();
    #10;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule